// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external 16-bit static RAM. The RAM has active-low chip enable, write enable, output enable and a separate enable for each byte lane. The host issues one word at a time on a valid/ready port. Each request carries an address, write data, a two-bit byte mask and a direction flag. Read results come back on a response port as a one-cycle valid pulse with the data.

Every memory access walks a fixed phase sequence, with each phase lasting a whole number of clock cycles:

1. Address and byte enables settle while all strobes are high.
2. Either write enable or output enable is pulled low.
3. A hold phase keeps address, lanes and, for writes, the driven data in place after the strobe ends.

The three phase lengths are parameters. The integrator picks them so that the phase length times the clock period covers the RAM's setup, pulse, hold and access times.

The controller never drives the data bus while the RAM outputs are enabled. When a read follows a write, or a write follows a read, the controller adds one dead cycle with the chip deselected. Between requests it deselects the chip so that the device falls to standby. The data bus is presented as separate out, drive-enable and in vectors for a pad ring to combine.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte enables are high (inactive), the data drive enable is 0, the host ready is 1 and the response valid is 0.
- R2: A write keeps chip enable and the selected byte enables low for SETUP_CYC cycles with write enable and output enable high. It then holds write enable low for exactly STROBE_CYC consecutive cycles. Output enable stays high for the whole write.
- R3: After write enable returns high, the address, the byte enables, chip enable (low) and the driven data stay unchanged for HOLD_CYC cycles.
- R4: A read holds output enable low for exactly STROBE_CYC cycles with write enable high. It samples the bus on the last of those cycles and raises the response valid for exactly one cycle. That pulse is seen SETUP_CYC+STROBE_CYC+1 cycles after the accepting edge.
- R5: Mask bit 0 drives byte enable 0 and selects data bits 7:0. Mask bit 1 drives byte enable 1 and selects bits 15:8. A write changes only the selected lanes.
- R6: On a read, a lane whose mask bit is 0 returns zero in the response, whatever the bus carries on that lane.
- R7: The data drive enable is high only during the setup, strobe and hold phases of a write, and never while output enable is low.
- R8: When a request's direction differs from that of the last memory access, one extra cycle with chip enable high comes before the setup phase. A request in the same direction starts setup in the cycle right after acceptance. The first access after reset counts as same-direction.
- R9: Whenever the host ready is high, chip enable, write enable and output enable are high and the bus is not driven.
- R10: A request with a zero mask never strobes the memory and is ready again in the next cycle. For a read it returns response valid with zero data in the next cycle. It does not count as the last access for R8.
- R11: The host ready is low from the cycle after a memory access is accepted until that access's hold phase ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | LANES*LANE_W | Write data |
| reqMask | input | LANES | Byte lane mask, bit i selects lane i |
| rspValid | output | 1 | One-cycle read response strobe |
| rspData | output | LANES*LANE_W | Read data, unselected lanes zero |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | LANES | Byte enables, active low |
| memDqOut | output | LANES*LANE_W | Data to the memory |
| memDqOe | output | 1 | Data bus drive enable |
| memDqIn | input | LANES*LANE_W | Data from the memory |

## Verification
The bench sweeps every address of a small memory with full-word writes and reads, then single-lane writes and reads. It counts the exact length of every write-enable and output-enable pulse. A design that sampled early or strobed for the wrong count would show wrong data or a wrong pulse length. At every cycle it checks whether the bus is being driven into enabled RAM outputs. It also checks whether the data is dropped before the hold phase is over.

Unselected lanes are fed a junk byte, so a design that failed to mask them returns junk in the response. Direction changes are timed through the first cycle after acceptance, which exposes a missing or misplaced turnaround cycle. Zero-mask requests are checked for stray write pulses, for a changed word and for a spurious turnaround.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request fields
    logic capture;   // sample read data this cycle
    logic rspZero;   // zero-mask read: answer with zero
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic driveOn;
  } dpCtrl_t;

endpackage

// File: rtl/async_sram_ctrl_fsm.sv
module async_sram_ctrl_fsm
  import async_sram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    maskZero,
  output logic    reqReady,
  output dpCtrl_t ctrl
);

  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CYC = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             opWrite;
  logic             lastValid;
  logic             lastWrite;
  logic             accept;
  logic             needTurn;
  logic             inBus;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign needTurn = lastValid && (lastWrite != reqWrite);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opWrite   <= 1'b0;
      lastValid <= 1'b0;
      lastWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept && !maskZero) begin
            opWrite <= reqWrite;
            state   <= needTurn ? ST_TURN : ST_SETUP;
          end
        end
        ST_TURN: state <= ST_SETUP;
        ST_SETUP: begin
          if (cnt == SETUP_LAST) begin
            cnt   <= '0;
            state <= ST_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == STROBE_LAST) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == HOLD_LAST) begin
            cnt       <= '0;
            state     <= ST_IDLE;
            lastValid <= 1'b1;
            lastWrite <= opWrite;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inBus = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

  always_comb begin
    ctrl         = '0;
    ctrl.load    = accept;
    ctrl.rspZero = accept && maskZero && !reqWrite;
    ctrl.capture = (state == ST_STROBE) && !opWrite && (cnt == STROBE_LAST);
    ctrl.ceOn    = inBus;
    ctrl.weOn    = (state == ST_STROBE) && opWrite;
    ctrl.oeOn    = (state == ST_STROBE) && !opWrite;
    ctrl.driveOn = inBus && opWrite;
  end

endmodule

// File: rtl/async_sram_ctrl_dp.sv
module async_sram_ctrl_dp
  import async_sram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 ctrl,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LANES*LANE_W-1:0] reqWdata,
  input  logic [LANES-1:0]        reqMask,
  output logic                    rspValid,
  output logic [LANES*LANE_W-1:0] rspData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memCeN,
  output logic                    memWeN,
  output logic                    memOeN,
  output logic [LANES-1:0]        memBeN,
  output logic [LANES*LANE_W-1:0] memDqOut,
  output logic                    memDqOe,
  input  logic [LANES*LANE_W-1:0] memDqIn
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] laneData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (ctrl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneData[g*LANE_W +: LANE_W] = maskQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
    assign memBeN[g] = !(ctrl.ceOn && maskQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= ctrl.capture || ctrl.rspZero;
      if (ctrl.capture) begin
        rspData <= laneData;
      end else if (ctrl.rspZero) begin
        rspData <= '0;
      end
    end
  end

  assign memAddr  = addrQ;
  assign memCeN   = !ctrl.ceOn;
  assign memWeN   = !ctrl.weOn;
  assign memOeN   = !ctrl.oeOn;
  assign memDqOut = wdataQ;
  assign memDqOe  = ctrl.driveOn;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import async_sram_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LANE_W     = 8,
  parameter int LANES      = 2,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LANES*LANE_W-1:0] reqWdata,
  input  logic [LANES-1:0]        reqMask,
  output logic                    rspValid,
  output logic [LANES*LANE_W-1:0] rspData,
  output logic [ADDR_W-1:0]       memAddr,
  output logic                    memCeN,
  output logic                    memWeN,
  output logic                    memOeN,
  output logic [LANES-1:0]        memBeN,
  output logic [LANES*LANE_W-1:0] memDqOut,
  output logic                    memDqOe,
  input  logic [LANES*LANE_W-1:0] memDqIn
);

  dpCtrl_t ctrl;
  logic    maskZero;

  assign maskZero = (reqMask == '0);

  async_sram_ctrl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .maskZero(maskZero),
    .reqReady(reqReady),
    .ctrl    (ctrl)
  );

  async_sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .rspValid(rspValid),
    .rspData (rspData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memBeN  (memBeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqReady,
  input logic                    rspValid,
  input logic [ADDR_W-1:0]       memAddr,
  input logic                    memCeN,
  input logic                    memWeN,
  input logic                    memOeN,
  input logic [LANES-1:0]        memBeN,
  input logic [LANES*LANE_W-1:0] memDqOut,
  input logic                    memDqOe
);

  // R2, R4: the two strobes are never low together
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  // R2: a strobe only fires with the chip and at least one lane selected
  assert_strobe_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> (!memCeN && !(&memBeN)));

  // R7: never drive into enabled outputs
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  // R9: standby whenever ready
  assert_standby_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && !memDqOe));

  // R3: data, address and lanes held past the end of the write pulse
  assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && !memCeN && $stable(memDqOut)
                       && $stable(memAddr) && $stable(memBeN)));

  // R5: address and lanes do not move inside a write pulse
  assert_pulse_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memBeN)));

  // R4: response is a single-cycle pulse
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LANE_W(LANE_W),
  .LANES (LANES)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memAddr (memAddr),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memBeN  (memBeN),
  .memDqOut(memDqOut),
  .memDqOe (memDqOe)
);

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb_top;

  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;
  localparam int SETUP  = 2;
  localparam int STROBE = 3;
  localparam int HOLD   = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0]   reqWdata = '0;
  logic [1:0]    reqMask = '0;
  logic          rspValid;
  logic [15:0]   rspData;
  logic [AW-1:0] memAddr;
  logic          memCeN, memWeN, memOeN, memDqOe;
  logic [1:0]    memBeN;
  logic [15:0]   memDqOut;
  logic [15:0]   memDqIn;

  int nChecks = 0;
  int nFail   = 0;
  int weFalls = 0;

  logic [15:0] memArr [DEPTH];
  logic [15:0] shadow [DEPTH];

  always #4 clk = ~clk;

  async_sram_ctrl #(
    .ADDR_W(AW), .LANE_W(8), .LANES(2),
    .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model: unselected lanes carry junk 8'hEE, idle bus 16'hBAD0
  assign memDqIn = (!memCeN && !memOeN && memWeN) ?
    {(!memBeN[1] ? memArr[memAddr][15:8] : 8'hEE),
     (!memBeN[0] ? memArr[memAddr][7:0]  : 8'hEE)} : 16'hBAD0;

  always @(posedge memWeN) begin
    if (memCeN === 1'b0) begin
      if (!memBeN[0]) memArr[memAddr][7:0]  <= memDqOut[7:0];
      if (!memBeN[1]) memArr[memAddr][15:8] <= memDqOut[15:8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse-length and contention monitor
  int  weRun = 0;
  int  oeRun = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memDqOe && !memOeN) check(0, "R7 contention", 1, 0);
      if (!memWeN) begin
        if (weRun == 0) weFalls++;
        weRun++;
        if (!memOeN) check(0, "R2 oe low in write", 0, 1);
      end else if (weRun != 0) begin
        check(weRun == STROBE, "R2 write pulse length", weRun, STROBE);
        check(memDqOe && !memCeN, "R3 hold after write", {memDqOe, memCeN}, 2'b10);
        weRun = 0;
      end
      if (!memOeN) oeRun++;
      else if (oeRun != 0) begin
        check(oeRun == STROBE, "R4 read pulse length", oeRun, STROBE);
        oeRun = 0;
      end
    end
  end

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [1:0] m, output logic [15:0] rd,
                      output int firstCe, output int rspLat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    firstCe = int'(memCeN);
    rspLat = 1;
    rd = '0;
    if (m != 2'b00) check(!reqReady, "R11 busy after accept", reqReady, 0);
    if (!wr) begin
      while (!rspValid) begin @(negedge clk); rspLat++; end
      rd = rspData;
    end
    while (!reqReady) @(negedge clk);
    check(memCeN, "R9 standby when ready", memCeN, 1);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0103) ^ 16'h5AC3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] exp;
    int fc, lat, wf;
    for (int i = 0; i < DEPTH; i++) memArr[i] = 16'h0000;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({memCeN, memWeN, memOeN, memBeN} == 5'b11111, "R1 strobes idle",
          {memCeN, memWeN, memOeN, memBeN}, 5'b11111);
    check(!memDqOe && reqReady && !rspValid, "R1 bus/ready/rsp",
          {memDqOe, reqReady, rspValid}, 3'b010);

    // full-word write sweep, R2 R8 (same direction, first after reset)
    for (int a = 0; a < DEPTH; a++) begin
      doOp(1'b1, AW'(a), pat(a), 2'b11, rd, fc, lat);
      shadow[a] = pat(a);
      if (a < 4) check(fc == 0, "R8 no turnaround same dir", fc, 0);
    end

    // full-word read sweep, R4 R5, first read needs turnaround
    for (int a = 0; a < DEPTH; a++) begin
      doOp(1'b0, AW'(a), 16'h0, 2'b11, rd, fc, lat);
      check(rd == shadow[a], "R5 read word", rd, shadow[a]);
      if (a == 0) begin
        check(fc == 1, "R8 turnaround write->read", fc, 1);
        check(lat == SETUP + STROBE + 2, "R4 latency with turn", lat, SETUP + STROBE + 2);
      end else begin
        check(lat == SETUP + STROBE + 1, "R4 response latency", lat, SETUP + STROBE + 1);
      end
    end

    // single-lane reads, R6
    for (int a = 0; a < DEPTH; a += 7) begin
      doOp(1'b0, AW'(a), 16'h0, 2'b01, rd, fc, lat);
      check(rd == {8'h00, shadow[a][7:0]}, "R6 low lane only", rd, {8'h00, shadow[a][7:0]});
      doOp(1'b0, AW'(a), 16'h0, 2'b10, rd, fc, lat);
      check(rd == {shadow[a][15:8], 8'h00}, "R6 high lane only", rd, {shadow[a][15:8], 8'h00});
    end

    // byte writes, R5, R8 read->write
    doOp(1'b1, AW'(5), 16'hABCD, 2'b01, rd, fc, lat);
    check(fc == 1, "R8 turnaround read->write", fc, 1);
    shadow[5][7:0] = 8'hCD;
    doOp(1'b1, AW'(6), 16'h1234, 2'b10, rd, fc, lat);
    shadow[6][15:8] = 8'h12;
    doOp(1'b0, AW'(5), 16'h0, 2'b11, rd, fc, lat);
    check(rd == shadow[5], "R5 low-lane write", rd, shadow[5]);
    doOp(1'b0, AW'(6), 16'h0, 2'b11, rd, fc, lat);
    check(rd == shadow[6], "R5 high-lane write", rd, shadow[6]);

    // zero-mask write, R10
    wf = weFalls;
    doOp(1'b1, AW'(7), 16'hFFFF, 2'b00, rd, fc, lat);
    check(reqReady, "R10 zero-mask write ready next cycle", reqReady, 1);
    check(weFalls == wf, "R10 no write pulse", weFalls, wf);
    doOp(1'b0, AW'(7), 16'h0, 2'b11, rd, fc, lat);
    check(fc == 0, "R10 no turnaround after zero-mask", fc, 0);
    check(rd == shadow[7], "R10 word unchanged", rd, shadow[7]);

    // zero-mask read, R10
    doOp(1'b0, AW'(9), 16'h0, 2'b00, rd, fc, lat);
    check(lat == 1, "R10 zero-mask read latency", lat, 1);
    check(rd == 16'h0, "R10 zero-mask read data", rd, 0);
    check(fc == 1, "R10 zero-mask read no select", fc, 1);
    exp = shadow[9];
    doOp(1'b0, AW'(9), 16'h0, 2'b11, rd, fc, lat);
    check(rd == exp, "R4 read after zero-mask", rd, exp);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule